// File: doc/BRIEF.md
# Interrupt Priority and Vector Unit

This block sits between the interrupt request lines of a chip and its processor core. It latches request pulses from a parameterised set of maskable sources and from three non-maskable sources. It picks one winner and presents that winner's 16-bit exception code and 32-bit handler address to the core. Each maskable source has its own 3-bit priority level and mask bit. Arbitration among maskable sources runs in two stages: the most urgent level wins first, and a fixed per-source rank breaks ties between equal levels. A pending non-maskable request always wins over the maskable ones, and the three non-maskable sources rank among themselves in a fixed order.

The winner is registered and held steady until the core accepts it with a take handshake. The unit then gives a one-cycle acknowledge, clears the winner's pending flag and records which program counter the core must save. That is the interrupted instruction's own address when the core reports that instruction as abandoned and restartable (short-form load, divide, or a frame prepare/dispose before its stack-pointer update). Otherwise it is the address of the following instruction.

Top module: `irq_vector_unit`

## Requirements
- R1: A request pulse on a masked maskable source is latched as pending but produces no request at `req_o`. Once the mask bit is cleared, that source is presented one clock later.
- R2: Any pending non-maskable request wins over every maskable request, whatever the maskable levels are.
- R3: Non-maskable sources are served in the fixed order `nmi_i[2]`, then `nmi_i[1]`, then `nmi_i[0]`.
- R4: Among eligible maskable requests, the one with the numerically smallest level wins. Level 0 is the most urgent.
- R5: When eligible maskable requests share the smallest level, the source with the lowest index wins.
- R6: While `svc_active_i` is 1, a maskable request is eligible only if its level is strictly less than `cur_lvl_i`. While `svc_active_i` is 0, every unmasked request is eligible.
- R7: The exception code is `MASK_BASE + 16*i` for maskable source i (default `MASK_BASE` 0x0100). It is `NMI_BASE + 16*k` for `nmi_i[k]` (default `NMI_BASE` 0x0010), so each handler slot is 16 bytes.
- R8: `vec_o` equals `code_o` zero-extended to 32 bits.
- R9: `req_o` rises on the second rising clock edge after a request pulse is sampled: one edge latches the flag, one registers the winner. While `take_i` is 0, `req_o`, `code_o` and `is_nmi_o` stay fixed, even if a more urgent request arrives.
- R10: A `take_i` sampled while `req_o` is 1 gives `ack_o` high for exactly the next cycle. In that same cycle `req_o` is 0 and the winner's pending flag is cleared, so that source is not presented again unless it raises a new pulse.
- R11: With the acknowledge, `pc_sel_o` takes the value `restart_i` had at the take: 1 means save the interrupted instruction's own address, 0 means save the next instruction's address. It holds until the next acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | N_SRC | Maskable request pulses, one per source |
| irq_mask_i | input | N_SRC | Mask bits; 1 keeps the source out of arbitration |
| irq_lvl_i | input | 3*N_SRC | Priority level of source i in bits [3i+2:3i] |
| nmi_i | input | 3 | Non-maskable request pulses; bit 2 is ranked highest |
| svc_active_i | input | 1 | An interrupt is currently being serviced |
| cur_lvl_i | input | 3 | Level of the interrupt being serviced |
| take_i | input | 1 | Core accepts the presented request |
| restart_i | input | 1 | The interrupted instruction is abandoned and must re-execute |
| req_o | output | 1 | A winner is presented |
| is_nmi_o | output | 1 | The presented winner is non-maskable |
| code_o | output | 16 | Exception code of the winner |
| vec_o | output | 32 | Handler address of the winner |
| ack_o | output | 1 | One-cycle acknowledge after a take |
| pc_sel_o | output | 1 | Saved-PC choice: 1 current instruction, 0 next instruction |

## Verification
A wrong pending flag shows up at `req_o` at most two clocks after its cause. If a flag is lost, the request never appears. If a flag is not cleared, the same code comes back one cycle after the acknowledge. A fault in the level or rank comparison shows as a wrong `code_o` on the first cycle the winner is presented. The bench therefore sweeps every source pair under both distinct and equal levels, every level against the in-service threshold, and every combination of non-maskable sources. After each acknowledge it checks the order in which the remaining flags drain.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int LVL_W    = 3;
    localparam int NMI_N    = 3;
    localparam int NMI_IDXW = 2;
    localparam int CODE_W   = 16;
    localparam int VEC_W    = 32;

    function automatic logic [CODE_W-1:0] slot_code(input logic [CODE_W-1:0] base,
                                                    input int step, input int idx);
        return base + CODE_W'(step * idx);
    endfunction
endpackage

// File: rtl/irq_flags.sv
module irq_flags
    import irq_pkg::*;
#(
    parameter int N_SRC = 8,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N_SRC-1:0]    set_m_i,
    input  logic [NMI_N-1:0]    set_n_i,
    input  logic                clr_en_i,
    input  logic                clr_nmi_i,
    input  logic [IDX_W-1:0]    clr_idx_i,
    input  logic [NMI_IDXW-1:0] clr_nidx_i,
    output logic [N_SRC-1:0]    pend_m_o,
    output logic [NMI_N-1:0]    pend_n_o
);
    typedef struct packed {
        logic [N_SRC-1:0] m;
        logic [NMI_N-1:0] n;
    } flag_t;

    flag_t flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_en_i) begin
            if (clr_nmi_i) flag_d.n[clr_nidx_i] = 1'b0;
            else           flag_d.m[clr_idx_i]  = 1'b0;
        end
        // a fresh pulse in the clearing cycle survives
        flag_d.m = flag_d.m | set_m_i;
        flag_d.n = flag_d.n | set_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign pend_m_o = flag_q.m;
    assign pend_n_o = flag_q.n;
endmodule

// File: rtl/irq_arb.sv
module irq_arb
    import irq_pkg::*;
#(
    parameter int              N_SRC     = 8,
    parameter logic [15:0]     MASK_BASE = 16'h0100,
    parameter logic [15:0]     NMI_BASE  = 16'h0010,
    parameter int              CODE_STEP = 16,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]       pend_m_i,
    input  logic [NMI_N-1:0]       pend_n_i,
    input  logic [N_SRC-1:0]       mask_i,
    input  logic [N_SRC*LVL_W-1:0] lvl_i,
    input  logic                   svc_active_i,
    input  logic [LVL_W-1:0]       cur_lvl_i,
    output logic                   found_o,
    output logic                   nmi_o,
    output logic [IDX_W-1:0]       idx_o,
    output logic [NMI_IDXW-1:0]    nidx_o,
    output logic [LVL_W-1:0]       lvl_o,
    output logic [CODE_W-1:0]      code_o
);
    logic [N_SRC-1:0] elig;
    logic             m_found;
    logic [IDX_W-1:0] m_idx;
    logic [LVL_W-1:0] m_lvl;

    for (genvar g = 0; g < N_SRC; g++) begin : g_elig
        assign elig[g] = pend_m_i[g] && !mask_i[g] &&
                         (!svc_active_i || (lvl_i[g*LVL_W +: LVL_W] < cur_lvl_i));
    end

    // stage 1 level compare, stage 2 lowest index via strict less-than
    always_comb begin
        m_found = 1'b0;
        m_idx   = '0;
        m_lvl   = '1;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && (!m_found || (lvl_i[i*LVL_W +: LVL_W] < m_lvl))) begin
                m_found = 1'b1;
                m_idx   = IDX_W'(i);
                m_lvl   = lvl_i[i*LVL_W +: LVL_W];
            end
        end
    end

    always_comb begin
        nidx_o = '0;
        if (pend_n_i[2])      nidx_o = 2'd2;
        else if (pend_n_i[1]) nidx_o = 2'd1;
        nmi_o   = |pend_n_i;
        found_o = nmi_o || m_found;
        idx_o   = m_idx;
        lvl_o   = nmi_o ? '0 : m_lvl;
        code_o  = nmi_o ? slot_code(NMI_BASE, CODE_STEP, int'(nidx_o))
                        : slot_code(MASK_BASE, CODE_STEP, int'(m_idx));
    end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
    import irq_pkg::*;
#(
    parameter int          N_SRC     = 8,
    parameter logic [15:0] MASK_BASE = 16'h0100,
    parameter logic [15:0] NMI_BASE  = 16'h0010,
    parameter int          CODE_STEP = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_SRC-1:0]       irq_i,
    input  logic [N_SRC-1:0]       irq_mask_i,
    input  logic [N_SRC*3-1:0]     irq_lvl_i,
    input  logic [2:0]             nmi_i,
    input  logic                   svc_active_i,
    input  logic [2:0]             cur_lvl_i,
    input  logic                   take_i,
    input  logic                   restart_i,
    output logic                   req_o,
    output logic                   is_nmi_o,
    output logic [15:0]            code_o,
    output logic [31:0]            vec_o,
    output logic                   ack_o,
    output logic                   pc_sel_o
);
    localparam int IDX_W = $clog2(N_SRC);

    typedef struct packed {
        logic                valid;
        logic                nmi;
        logic [IDX_W-1:0]    idx;
        logic [NMI_IDXW-1:0] nidx;
        logic [LVL_W-1:0]    lvl;
        logic [CODE_W-1:0]   code;
        logic                ack;
        logic                pcsel;
    } sel_t;

    sel_t sel_d, sel_q;

    logic [N_SRC-1:0]    pend_m;
    logic [NMI_N-1:0]    pend_n;
    logic                a_found, a_nmi;
    logic [IDX_W-1:0]    a_idx;
    logic [NMI_IDXW-1:0] a_nidx;
    logic [LVL_W-1:0]    a_lvl;
    logic [CODE_W-1:0]   a_code;
    logic                clr_en;
    logic [LVL_W-1:0]    win_lvl_q;

    irq_flags #(.N_SRC(N_SRC)) i_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_m_i    (irq_i),
        .set_n_i    (nmi_i),
        .clr_en_i   (clr_en),
        .clr_nmi_i  (sel_q.nmi),
        .clr_idx_i  (sel_q.idx),
        .clr_nidx_i (sel_q.nidx),
        .pend_m_o   (pend_m),
        .pend_n_o   (pend_n)
    );

    irq_arb #(
        .N_SRC     (N_SRC),
        .MASK_BASE (MASK_BASE),
        .NMI_BASE  (NMI_BASE),
        .CODE_STEP (CODE_STEP)
    ) i_arb (
        .pend_m_i     (pend_m),
        .pend_n_i     (pend_n),
        .mask_i       (irq_mask_i),
        .lvl_i        (irq_lvl_i),
        .svc_active_i (svc_active_i),
        .cur_lvl_i    (cur_lvl_i),
        .found_o      (a_found),
        .nmi_o        (a_nmi),
        .idx_o        (a_idx),
        .nidx_o       (a_nidx),
        .lvl_o        (a_lvl),
        .code_o       (a_code)
    );

    always_comb begin
        sel_d     = sel_q;
        sel_d.ack = 1'b0;
        clr_en    = 1'b0;
        if (sel_q.valid) begin
            if (take_i) begin
                sel_d.valid = 1'b0;
                sel_d.ack   = 1'b1;
                sel_d.pcsel = restart_i;
                clr_en      = 1'b1;
            end
        end else begin
            sel_d.valid = a_found;
            sel_d.nmi   = a_nmi;
            sel_d.idx   = a_idx;
            sel_d.nidx  = a_nidx;
            sel_d.lvl   = a_lvl;
            sel_d.code  = a_code;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign req_o     = sel_q.valid;
    assign is_nmi_o  = sel_q.nmi;
    assign code_o    = sel_q.code;
    assign vec_o     = {16'h0000, sel_q.code};
    assign ack_o     = sel_q.ack;
    assign pc_sel_o  = sel_q.pcsel;
    assign win_lvl_q = sel_q.lvl;
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        take_i,
    input logic        restart_i,
    input logic        svc_active_i,
    input logic [2:0]  cur_lvl_i,
    input logic        req_o,
    input logic        is_nmi_o,
    input logic [15:0] code_o,
    input logic        ack_o,
    input logic        pc_sel_o,
    input logic [2:0]  win_lvl_q
);
    p_ack_after_take_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(take_i && req_o));

    p_ack_clears_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> !req_o);

    p_hold_until_take_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_o && !take_i) |=> (req_o && $stable(code_o) && $stable(is_nmi_o)));

    p_saved_pc_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> (pc_sel_o == $past(restart_i)));

    p_threshold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(req_o) && !is_nmi_o && $past(svc_active_i)) |-> (win_lvl_q < $past(cur_lvl_i)));
endmodule

bind irq_vector_unit irq_vector_unit_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_i       (take_i),
    .restart_i    (restart_i),
    .svc_active_i (svc_active_i),
    .cur_lvl_i    (cur_lvl_i),
    .req_o        (req_o),
    .is_nmi_o     (is_nmi_o),
    .code_o       (code_o),
    .ack_o        (ack_o),
    .pc_sel_o     (pc_sel_o),
    .win_lvl_q    (win_lvl_q)
);

// File: tb/test_irq_vector_unit.sv
module test_irq_vector_unit;
    localparam int N = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_i = '0;
    logic [N-1:0]  irq_mask_i = '0;
    logic [N*3-1:0] irq_lvl_i = '0;
    logic [2:0]    nmi_i = '0;
    logic          svc_active_i = 1'b0;
    logic [2:0]    cur_lvl_i = '0;
    logic          take_i = 1'b0;
    logic          restart_i = 1'b0;
    logic          req_o, is_nmi_o, ack_o, pc_sel_o;
    logic [15:0]   code_o;
    logic [31:0]   vec_o;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    irq_vector_unit i_irq_vector_unit (.*);

    always #4 clk = ~clk;

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_fail++;
            $display("FAIL R9 watchdog: act=%0d cycles exp=finish", cyc);
            finish_run();
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] mcode(input int i);
        return 16'h0100 + 16'(16 * i);
    endfunction

    function automatic logic [15:0] ncode(input int k);
        return 16'h0010 + 16'(16 * k);
    endfunction

    task automatic set_lvl(input int i, input int l);
        irq_lvl_i[i*3 +: 3] = 3'(l);
    endtask

    // pulse at a negedge; returns at the negedge after the winner register loads
    task automatic raise(input logic [N-1:0] m, input logic [2:0] n);
        @(negedge clk);
        irq_i = m; nmi_i = n;
        @(negedge clk);
        irq_i = '0; nmi_i = '0;
        @(negedge clk);
    endtask

    task automatic expect_win(input logic [15:0] code, input bit nmi, input string tag);
        check(req_o === 1'b1, {tag, " req"}, 32'(req_o), 32'd1);
        check(code_o === code, {tag, " code"}, 32'(code_o), 32'(code));
        check(is_nmi_o === nmi, {tag, " nmi"}, 32'(is_nmi_o), 32'(nmi));
    endtask

    task automatic take(input bit r, input bit verify);
        take_i = 1'b1; restart_i = r;
        @(negedge clk);
        take_i = 1'b0; restart_i = 1'b0;
        if (verify) begin
            check(ack_o === 1'b1, "R10 ack", 32'(ack_o), 32'd1);
            check(req_o === 1'b0, "R10 req low at ack", 32'(req_o), 32'd0);
            check(pc_sel_o === r, "R11 pc_sel", 32'(pc_sel_o), 32'(r));
        end
        @(negedge clk);
        if (verify) check(ack_o === 1'b0, "R10 ack one cycle", 32'(ack_o), 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_o === 1'b0 && ack_o === 1'b0 && pc_sel_o === 1'b0, "R10 reset state",
              {29'd0, req_o, ack_o, pc_sel_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 R8 R10 R11: every source alone, at the extreme levels
        for (int l = 0; l < 8; l += 7) begin
            for (int i = 0; i < N; i++) begin
                for (int s = 0; s < N; s++) set_lvl(s, l);
                raise(N'(1) << i, 3'b000);
                expect_win(mcode(i), 1'b0, "R7 single");
                check(vec_o === {16'h0, mcode(i)}, "R8 vector", vec_o, {16'h0, mcode(i)});
                take(i[0], 1'b1);
                check(req_o === 1'b0, "R10 flag cleared", 32'(req_o), 32'd0);
            end
        end

        // R9: latency and hold against a more urgent newcomer
        for (int s = 0; s < N; s++) set_lvl(s, 7);
        set_lvl(0, 0);
        @(negedge clk);
        irq_i = 8'h08;
        @(negedge clk);
        irq_i = '0;
        check(req_o === 1'b0, "R9 not after one edge", 32'(req_o), 32'd0);
        @(negedge clk);
        expect_win(mcode(3), 1'b0, "R9 after two edges");
        irq_i = 8'h01; nmi_i = 3'b001;
        @(negedge clk);
        irq_i = '0; nmi_i = '0;
        repeat (3) @(negedge clk);
        expect_win(mcode(3), 1'b0, "R9 held");
        take(1'b0, 1'b1);
        expect_win(ncode(0), 1'b1, "R2 nmi next");
        take(1'b0, 1'b1);
        expect_win(mcode(0), 1'b0, "R9 newcomer next");
        take(1'b1, 1'b1);
        check(req_o === 1'b0, "R10 drained", 32'(req_o), 32'd0);

        // R4 R5: all pairs, distinct-ish then equal levels
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    int li, lj, w, o;
                    if (i == j) continue;
                    li = (p == 0) ? (i + 2*j) % 8 : (i*j) % 8;
                    lj = (p == 0) ? (j + 3*i) % 8 : li;
                    set_lvl(i, li); set_lvl(j, lj);
                    if (li != lj) w = (li < lj) ? i : j;
                    else          w = (i < j) ? i : j;
                    o = (w == i) ? j : i;
                    raise((N'(1) << i) | (N'(1) << j), 3'b000);
                    expect_win(mcode(w), 1'b0, (li == lj) ? "R5 tie" : "R4 level");
                    take(1'b0, 1'b0);
                    expect_win(mcode(o), 1'b0, "R10 loser next");
                    take(1'b0, 1'b0);
                end
            end
        end
        check(req_o === 1'b0, "R10 pairs drained", 32'(req_o), 32'd0);

        // R1: masked source latched but absent
        for (int s = 0; s < N; s++) set_lvl(s, 2);
        irq_mask_i = 8'h04;
        raise(8'h04, 3'b000);
        repeat (2) @(negedge clk);
        check(req_o === 1'b0, "R1 masked absent", 32'(req_o), 32'd0);
        irq_mask_i = '0;
        @(negedge clk);
        expect_win(mcode(2), 1'b0, "R1 latched then unmasked");
        take(1'b0, 1'b1);

        // R6: threshold against level 4 in service
        svc_active_i = 1'b1; cur_lvl_i = 3'd4;
        for (int l = 0; l < 8; l++) begin
            for (int s = 0; s < N; s++) set_lvl(s, l);
            raise(8'h40, 3'b000);
            if (l < 4) begin
                expect_win(mcode(6), 1'b0, "R6 more urgent taken");
                take(1'b0, 1'b0);
            end else begin
                check(req_o === 1'b0, "R6 not more urgent held off", 32'(req_o), 32'd0);
                svc_active_i = 1'b0;
                @(negedge clk);
                expect_win(mcode(6), 1'b0, "R6 released when idle");
                svc_active_i = 1'b1;
                take(1'b0, 1'b0);
            end
        end
        svc_active_i = 1'b0;
        check(req_o === 1'b0, "R6 drained", 32'(req_o), 32'd0);

        // R2 R3: every non-maskable combination against an urgent maskable
        for (int s = 0; s < N; s++) set_lvl(s, 0);
        for (int c = 1; c < 8; c++) begin
            raise(8'h01, 3'(c));
            for (int k = 2; k >= 0; k--) begin
                if (c[k]) begin
                    expect_win(ncode(k), 1'b1, "R3 nmi order");
                    take(1'b1, 1'b0);
                end
            end
            expect_win(mcode(0), 1'b0, "R2 maskable after nmi");
            take(1'b0, 1'b0);
        end
        check(req_o === 1'b0, "R3 drained", 32'(req_o), 32'd0);

        finish_run();
    end
endmodule